// File: doc/BRIEF.md
# Significand Adder with Parallel Round Selection

This block finishes the effective-addition path of a floating-point adder. It takes two significands that are already aligned, together with the guard and sticky information shifted out of the smaller one and the common exponent. It returns a normalized significand rounded to nearest-even, the adjusted exponent and an inexact indication. There is no increment stage after the add. Two results are formed at the same time, the plain sum and the sum plus one, and the rounding decision selects one of them.

A carry out of the top significand bit is handled with a one-position right shift done by a multiplexer, and the exponent is incremented. In that case the round bit is the lowest bit of the raw sum. The selection then takes the upper bits of sum+1, so the increment effectively enters at the round position and carries into the new LSB. If rounding up a sum made of all ones produces a carry, the result wraps to the leading-one pattern and the exponent is incremented. The block is purely combinational.

Top module: `sig_round_add`

## Requirements
- R1: With no carry out of the W-bit sum and no round-up, `sig_out` equals the low W bits of `op_a + op_b` and `exp_out` equals `exp_in`.
- R2: When `op_a + op_b` carries out of W bits, `sig_out` is that (W+1)-bit sum shifted right by one after rounding, and `exp_out` is `exp_in + 1`.
- R3: Without carry, a set guard bit together with a set sticky bit selects sum+1, so the result is one higher than the sum.
- R4: Without carry, a tie (guard 1, sticky 0) rounds up only when the LSB of the sum is 1, so the result is even.
- R5: Without carry, a clear guard bit keeps the sum unchanged, whatever the sticky bit holds.
- R6: With carry, raw sum bit 0 acts as the round bit, raw sum bit 1 as the LSB, and guard OR sticky as the sticky. Round-half-even is applied to these, and a round-up produces the shifted sum plus one.
- R7: When rounding up in the no-carry case overflows W bits, `sig_out` is a 1 followed by zeros and `exp_out` is `exp_in + 1`.
- R8: `inexact` is 1 exactly when any discarded bit is nonzero: guard or sticky, plus raw sum bit 0 in the carry case.
- R9: The exponent increment wraps modulo 2^E.
- R10: When `op_a` has its top bit set, `sig_out` has its top bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Larger significand, hidden bit in the top position |
| op_b | input | W | Aligned smaller significand, integer part |
| guard_in | input | 1 | First bit shifted out of `op_b` during alignment |
| sticky_in | input | 1 | OR of all further bits shifted out of `op_b` |
| exp_in | input | E | Common exponent of the aligned operands |
| sig_out | output | W | Normalized, rounded significand |
| exp_out | output | E | Exponent after normalization |
| inexact | output | 1 | Some precision was discarded |

## Verification
Directed vectors separate the three result paths: a plain sum, a sum with carry-out, and the all-ones sum that wraps on round-up. Within each path, the guard and sticky values are set to below-half, above-half and tie, with both LSB parities, so that each ordering of the round decision is shown apart. A vector with the maximum exponent and a carry shows the exponent wrap. A pseudo-random sweep of normalized operands with varied alignment is compared against a reference that adds wide integers and rounds explicitly.

// File: rtl/sra_pkg.sv
package sra_pkg;

    // Which normalization the result took.
    typedef enum logic [1:0] {
        PATH_KEEP  = 2'd0,  // no carry: W-bit result stays in place
        PATH_CARRY = 2'd1,  // add carried out: shift right by one
        PATH_WRAP  = 2'd2   // round-up of all ones carried out
    } path_e;

endpackage

// File: rtl/sra_compound_adder.sv
module sra_compound_adder #(
    parameter int W = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum0,
    output logic [W:0]   sum1
);
    localparam int SW = W + 1;

    // Carry-select style: per-bit propagate and generate shared by both results.
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W:0]   c0;
    logic [W:0]   c1;

    assign prop  = a ^ b;
    assign gen   = a & b;
    assign c0[0] = 1'b0;
    assign c1[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign c0[i+1] = gen[i] | (prop[i] & c0[i]);
        assign c1[i+1] = gen[i] | (prop[i] & c1[i]);
    end

    assign sum0 = SW'({c0[W], prop ^ c0[W-1:0]});
    assign sum1 = SW'({c1[W], prop ^ c1[W-1:0]});

    always_comb begin
        p_pair_step_r1: assert (sum1 == sum0 + 1'b1 || (&sum0))
            else $error("sum1 is not sum0 plus one");
    end
endmodule

// File: rtl/sra_round_select.sv
module sra_round_select (
    input  logic carry,
    input  logic raw_b1,
    input  logic raw_b0,
    input  logic guard,
    input  logic sticky,
    output logic pick_inc,
    output logic inexact
);
    logic lsb;
    logic rbit;
    logic tail;

    always_comb begin
        if (carry) begin
            lsb  = raw_b1;
            rbit = raw_b0;
            tail = guard | sticky;
        end else begin
            lsb  = raw_b0;
            rbit = guard;
            tail = sticky;
        end
        pick_inc = rbit & (tail | lsb);
        inexact  = rbit | tail;
    end

    always_comb begin
        p_exact_no_inc_r8: assert (inexact || !pick_inc)
            else $error("round-up chosen for an exact sum");
    end
endmodule

// File: rtl/sra_norm_mux.sv
module sra_norm_mux #(
    parameter int W = 24,
    parameter int E = 8
) (
    input  logic [W:0]        sum0,
    input  logic [W:0]        sum1,
    input  logic              pick_inc,
    input  logic [E-1:0]      exp_in,
    output logic [W-1:0]      sig_out,
    output logic [E-1:0]      exp_out,
    output sra_pkg::path_e    path
);
    import sra_pkg::*;

    logic [E-1:0] exp_up;
    assign exp_up = E'(exp_in + 1'b1);

    always_comb begin
        if (sum0[W])
            path = PATH_CARRY;
        else if (pick_inc && sum1[W])
            path = PATH_WRAP;
        else
            path = PATH_KEEP;
    end

    always_comb begin
        unique case (path)
            PATH_KEEP: begin
                sig_out = pick_inc ? sum1[W-1:0] : sum0[W-1:0];
                exp_out = exp_in;
            end
            PATH_CARRY: begin
                sig_out = pick_inc ? sum1[W:1] : sum0[W:1];
                exp_out = exp_up;
            end
            PATH_WRAP: begin
                sig_out = sum1[W:1];
                exp_out = exp_up;
            end
            default: begin
                sig_out = sum0[W-1:0];
                exp_out = exp_in;
            end
        endcase
    end

    always_comb begin
        p_keep_exp_r1: assert (path != PATH_KEEP || exp_out == exp_in)
            else $error("exponent moved without carry");
        p_wrap_pattern_r7: assert (path != PATH_WRAP || sig_out == {1'b1, {(W-1){1'b0}}})
            else $error("wrap result is not a leading one");
    end
endmodule

// File: rtl/sig_round_add.sv
module sig_round_add #(
    parameter int W = 24,
    parameter int E = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         guard_in,
    input  logic         sticky_in,
    input  logic [E-1:0] exp_in,
    output logic [W-1:0] sig_out,
    output logic [E-1:0] exp_out,
    output logic         inexact
);
    import sra_pkg::*;

    logic [W:0] sum0;
    logic [W:0] sum1;
    logic       pick_inc;
    path_e      path;

    sra_compound_adder #(.W(W)) u_add (
        .a    (op_a),
        .b    (op_b),
        .sum0 (sum0),
        .sum1 (sum1)
    );

    sra_round_select u_rsel (
        .carry    (sum0[W]),
        .raw_b1   (sum0[1]),
        .raw_b0   (sum0[0]),
        .guard    (guard_in),
        .sticky   (sticky_in),
        .pick_inc (pick_inc),
        .inexact  (inexact)
    );

    sra_norm_mux #(.W(W), .E(E)) u_norm (
        .sum0     (sum0),
        .sum1     (sum1),
        .pick_inc (pick_inc),
        .exp_in   (exp_in),
        .sig_out  (sig_out),
        .exp_out  (exp_out),
        .path     (path)
    );

    always_comb begin
        p_exp_step_r9: assert (exp_out == exp_in || exp_out == E'(exp_in + 1'b1))
            else $error("exponent moved by more than one");
        p_carry_exp_r2: assert (!sum0[W] || exp_out == E'(exp_in + 1'b1))
            else $error("carry without exponent increment");
        p_norm_msb_r10: assert (!op_a[W-1] || sig_out[W-1])
            else $error("result lost its leading one");
    end
endmodule

// File: tb/sig_round_add_tb_top.sv
module sig_round_add_tb_top;
    localparam int W = 24;
    localparam int E = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] op_a, op_b, sig_out;
    logic         guard_in, sticky_in, inexact;
    logic [E-1:0] exp_in, exp_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic done   = 1'b0;

    sig_round_add #(.W(W), .E(E)) dut_i (
        .op_a(op_a), .op_b(op_b), .guard_in(guard_in), .sticky_in(sticky_in),
        .exp_in(exp_in), .sig_out(sig_out), .exp_out(exp_out), .inexact(inexact)
    );

    // Wide-integer reference: scale by 4, guard at bit 1, sticky at bit 0.
    function automatic void ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic g, input logic s, input logic [E-1:0] e,
                                      output logic [W-1:0] so, output logic [E-1:0] eo,
                                      output logic ix);
        longint v, q, rem, half;
        logic [E-1:0] ex;
        v  = ((longint'(a) + longint'(b)) << 2) | (longint'(g) << 1) | longint'(s);
        ex = e;
        if (v >= (longint'(1) << (W + 2))) begin
            q = v >> 3; rem = v & 7; half = 4; ex = E'(ex + 1'b1);
        end else begin
            q = v >> 2; rem = v & 3; half = 2;
        end
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (q >= (longint'(1) << W)) begin
            q = q >> 1; ex = E'(ex + 1'b1);
        end
        so = q[W-1:0];
        eo = ex;
        ix = (rem != 0);
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic g, input logic s, input logic [E-1:0] e);
        @(posedge clk);
        #1;
        op_a = a; op_b = b; guard_in = g; sticky_in = s; exp_in = e;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [W-1:0] xs,
                              input logic [E-1:0] xe, input logic xi);
        n_checks++;
        if (sig_out !== xs || exp_out !== xe || inexact !== xi) begin
            n_fail++;
            $display("FAIL %s: sig=%h exp=%h inexact=%b expected sig=%h exp=%h inexact=%b",
                     tag, sig_out, exp_out, inexact, xs, xe, xi);
        end
    endtask

    task automatic t_zero();
        drive('0, '0, 1'b0, 1'b0, '0);
        expect_out("R1 zero inputs", '0, '0, 1'b0);
    endtask

    task automatic t_exact();
        drive(24'h800000, 24'h000123, 1'b0, 1'b0, 8'h40);
        expect_out("R1 exact sum", 24'h800123, 8'h40, 1'b0);
    endtask

    task automatic t_carry_exact();
        drive(24'hC00000, 24'hC00000, 1'b0, 1'b0, 8'h10);
        expect_out("R2 carry shift", 24'hC00000, 8'h11, 1'b0);
    endtask

    task automatic t_above_half();
        drive(24'h800000, 24'h000001, 1'b1, 1'b1, 8'h20);
        expect_out("R3 above half", 24'h800002, 8'h20, 1'b1);
    endtask

    task automatic t_ties();
        drive(24'h800000, 24'h000000, 1'b1, 1'b0, 8'h20);
        expect_out("R4 tie even lsb", 24'h800000, 8'h20, 1'b1);
        drive(24'h800000, 24'h000001, 1'b1, 1'b0, 8'h20);
        expect_out("R4 tie odd lsb", 24'h800002, 8'h20, 1'b1);
    endtask

    task automatic t_below_half();
        drive(24'h800001, 24'h000000, 1'b0, 1'b1, 8'h20);
        expect_out("R5 below half", 24'h800001, 8'h20, 1'b1);
    endtask

    task automatic t_carry_round();
        drive(24'hFFFFFF, 24'h000002, 1'b0, 1'b0, 8'h30);
        expect_out("R6 carry tie even", 24'h800000, 8'h31, 1'b1);
        drive(24'hFFFFFF, 24'h000002, 1'b0, 1'b1, 8'h30);
        expect_out("R6 carry above half", 24'h800001, 8'h31, 1'b1);
        drive(24'hFFFFFF, 24'h000004, 1'b0, 1'b0, 8'h30);
        expect_out("R6 carry tie odd", 24'h800002, 8'h31, 1'b1);
        drive(24'hFFFFFF, 24'h000001, 1'b1, 1'b0, 8'h30);
        expect_out("R8 carry guard only", 24'h800000, 8'h31, 1'b1);
    endtask

    task automatic t_wrap();
        drive(24'hFFFFFE, 24'h000001, 1'b1, 1'b1, 8'h05);
        expect_out("R7 round wrap", 24'h800000, 8'h06, 1'b1);
    endtask

    task automatic t_exp_wrap();
        drive(24'hC00000, 24'hC00000, 1'b0, 1'b0, 8'hFF);
        expect_out("R9 exponent wrap", 24'hC00000, 8'h00, 1'b0);
    endtask

    task automatic t_sweep();
        logic [31:0] st = 32'h1234_5678;
        logic [W-1:0] a, b, xs;
        logic [E-1:0] xe;
        logic xi;
        for (int i = 0; i < 400; i++) begin
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            a  = {1'b1, st[W-2:0]};
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            b  = {1'b1, st[W-2:0]} >> st[28:27];
            drive(a, b, st[30], st[31], st[E-1:0]);
            ref_model(a, b, st[30], st[31], st[E-1:0], xs, xe, xi);
            expect_out("R10 sweep vs reference", xs, xe, xi);
            n_checks++;
            if (!sig_out[W-1]) begin
                n_fail++;
                $display("FAIL R10 leading one: sig=%h expected top bit 1", sig_out);
            end
        end
    endtask

    initial begin
        op_a = '0; op_b = '0; guard_in = 1'b0; sticky_in = 1'b0; exp_in = '0;
        t_zero();
        t_exact();
        t_carry_exact();
        t_above_half();
        t_ties();
        t_below_half();
        t_carry_round();
        t_wrap();
        t_exp_wrap();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule